// File: doc/BRIEF.md
# Keyboard Matrix Scan Port

This block gives a processor access to a 16-row keyboard matrix. The matrix contacts are active low. The processor writes one control byte. The low nibble of that byte picks the row to scan. Other bits switch a beeper enable and open the column readout. The block drives the selected row low on a one-hot, active-low strobe bus. The eight column lines return through a two-stage synchronizer and are inverted, so a pressed key reads back as 1.

Three row codes also act as commands for two indicator LEDs. These LEDs are a caps-lock lamp and an alternate-mode lamp. Each LED is held in a flip-flop that changes only when the control byte is written. The whole control byte is kept and driven out to the keyboard unit. Key debouncing and beeper tone generation belong to other logic.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset the held control byte is 0x00. Row 0 is selected (strobe bus 16'hFFFE), the beeper is off, the read port returns 0x00 and both LEDs are off.
- R2: A write loads bits 3:0 as the row index. From the next cycle, `row_idx` equals that index. `row_strobe_n` has only that bit at 0 and every other bit at 1.
- R3: Bit 4 of the last written byte drives `beep_en` (1 = beeper on).
- R4: While bit 5 of the held byte is 0, `rd_data` is 0x00 whatever the columns are.
- R5: While bit 5 is 1, `rd_data` is the bitwise inverse of `col_n` as sampled two rising edges earlier. A column change shows on `rd_data` after exactly two clock edges.
- R6: `kbd_ctrl` holds the full written byte, including bits 7:6. Bits 7:6 have no effect on row selection, the beeper or the read gate.
- R7: A write whose row index is 13 turns `led_caps` on and leaves `led_alt` as it was.
- R8: A write whose row index is 14 turns `led_alt` on and leaves `led_caps` as it was.
- R9: A write whose row index is 15 turns both LEDs off.
- R10: A write with any row index from 0 to 12 leaves both LEDs unchanged. Without a write, the control byte and the LEDs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| col_n | input | COLS | Matrix column lines, active low |
| rd_data | output | COLS | Gated, inverted column readout |
| row_idx | output | 4 | Selected row index |
| row_strobe_n | output | 16 | One-hot active-low row drive |
| beep_en | output | 1 | Beeper enable |
| led_caps | output | 1 | Caps-lock indicator |
| led_alt | output | 1 | Alternate-mode indicator |
| kbd_ctrl | output | 8 | Held control byte |

## Verification
Row index, strobe bus, beeper, gate and LEDs change one cycle after a write, when the registered byte updates. A column change reaches `rd_data` only after two further edges, because of the synchronizer. The bench drives every input on the falling edge and samples on a falling edge. It samples straight after the write edge for control results. For column results it samples once after the first edge, expecting the old value, and again after the second edge, expecting the new value. LED checks use writes to rows 13, 14 and 15 in mixed orders, writes to ordinary rows and idle cycles between them.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    localparam int unsigned ROWS   = 16;
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned CTRL_W = 8;

    localparam logic [ROW_W-1:0] ROW_CAPS_ON = 4'd13;
    localparam logic [ROW_W-1:0] ROW_ALT_ON  = 4'd14;
    localparam logic [ROW_W-1:0] ROW_LED_OFF = 4'd15;

    typedef struct packed {
        logic [1:0]       spare;
        logic             rd_open;
        logic             beep;
        logic [ROW_W-1:0] row;
    } kbd_ctrl_t;

    typedef struct packed {
        logic caps;
        logic alt;
    } kbd_led_t;

    function automatic kbd_led_t led_next(input logic [ROW_W-1:0] row,
                                          input kbd_led_t cur);
        kbd_led_t nxt;
        nxt = cur;
        case (row)
            ROW_CAPS_ON: nxt.caps = 1'b1;
            ROW_ALT_ON:  nxt.alt  = 1'b1;
            ROW_LED_OFF: nxt      = '0;
            default:     nxt      = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
    import kbd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output kbd_ctrl_t         ctrl_q,
    output kbd_led_t          led_q
);

    kbd_ctrl_t wr_ctrl;
    assign wr_ctrl = kbd_ctrl_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            led_q  <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_ctrl;
            led_q  <= led_next(wr_ctrl.row, led_q);
        end
    end

endmodule

// File: rtl/kbd_col_sync.sv
module kbd_col_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= d_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_row_drive.sv
module kbd_row_drive
    import kbd_scan_pkg::*;
(
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  strobe_n
);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign strobe_n[r] = (row != r[ROW_W-1:0]);
        end
    endgenerate

endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port
    import kbd_scan_pkg::*;
#(
    parameter int unsigned COLS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CTRL_W-1:0]     wr_data,
    input  logic [COLS-1:0]       col_n,
    output logic [COLS-1:0]       rd_data,
    output logic [ROW_W-1:0]      row_idx,
    output logic [ROWS-1:0]       row_strobe_n,
    output logic                  beep_en,
    output logic                  led_caps,
    output logic                  led_alt,
    output logic [CTRL_W-1:0]     kbd_ctrl
);

    kbd_ctrl_t        ctrl_q;
    kbd_led_t         led_q;
    logic [COLS-1:0]  col_sync_n;

    kbd_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .led_q   (led_q)
    );

    kbd_col_sync #(.WIDTH(COLS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (col_n),
        .d_out (col_sync_n)
    );

    kbd_row_drive u_rows (
        .row      (ctrl_q.row),
        .strobe_n (row_strobe_n)
    );

    assign rd_data  = ctrl_q.rd_open ? ~col_sync_n : '0;
    assign row_idx  = ctrl_q.row;
    assign beep_en  = ctrl_q.beep;
    assign led_caps = led_q.caps;
    assign led_alt  = led_q.alt;
    assign kbd_ctrl = CTRL_W'(ctrl_q);

endmodule

// File: rtl/kbd_scan_port_chk.sv
module kbd_scan_port_chk
    import kbd_scan_pkg::*;
#(
    parameter int unsigned COLS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [COLS-1:0]   col_n,
    input logic [COLS-1:0]   rd_data,
    input logic [ROW_W-1:0]  row_idx,
    input logic [ROWS-1:0]   row_strobe_n,
    input logic              beep_en,
    input logic              led_caps,
    input logic              led_alt,
    input logic [CTRL_W-1:0] kbd_ctrl
);

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    p_row_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> row_idx == $past(wr_data[ROW_W-1:0]));

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_strobe_n) == 1 && !row_strobe_n[row_idx]);

    p_beep_bit_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> beep_en == $past(wr_data[4]));

    p_gate_closed_r4: assert property (@(posedge clk) disable iff (rst)
        !kbd_ctrl[5] |-> rd_data == '0);

    p_sync_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && kbd_ctrl[5]) |-> rd_data == ~$past(col_n, 2));

    p_full_byte_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> kbd_ctrl == $past(wr_data));

    p_caps_on_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ROW_W-1:0] == ROW_CAPS_ON) |=> led_caps && $stable(led_alt));

    p_alt_on_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ROW_W-1:0] == ROW_ALT_ON) |=> led_alt && $stable(led_caps));

    p_leds_off_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ROW_W-1:0] == ROW_LED_OFF) |=> !led_caps && !led_alt);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(kbd_ctrl) && $stable(led_caps) && $stable(led_alt));

    p_plain_row_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ROW_W-1:0] < ROW_CAPS_ON) |=> $stable(led_caps) && $stable(led_alt));

endmodule

bind kbd_scan_port kbd_scan_port_chk #(.COLS(COLS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .col_n        (col_n),
    .rd_data      (rd_data),
    .row_idx      (row_idx),
    .row_strobe_n (row_strobe_n),
    .beep_en      (beep_en),
    .led_caps     (led_caps),
    .led_alt      (led_alt),
    .kbd_ctrl     (kbd_ctrl)
);

// File: tb/test_kbd_scan_port.sv
`timescale 1ns/1ps
module test_kbd_scan_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  col_n = 8'hFF;
    logic [7:0]  rd_data;
    logic [3:0]  row_idx;
    logic [15:0] row_strobe_n;
    logic        beep_en, led_caps, led_alt;
    logic [7:0]  kbd_ctrl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kbd_scan_port i_kbd_scan_port (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .col_n        (col_n),
        .rd_data      (rd_data),
        .row_idx      (row_idx),
        .row_strobe_n (row_strobe_n),
        .beep_en      (beep_en),
        .led_caps     (led_caps),
        .led_alt      (led_alt),
        .kbd_ctrl     (kbd_ctrl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset;
        check("R1 ctrl", kbd_ctrl, 8'h00);
        check("R1 row", row_idx, 0);
        check("R1 strobe", row_strobe_n, 16'hFFFE);
        check("R1 beep", beep_en, 0);
        check("R1 rd", rd_data, 0);
        check("R1 leds", {led_caps, led_alt}, 0);
    endtask

    task automatic t_rows;
        for (int r = 0; r < 16; r++) begin
            write_ctrl(8'(r));
            check("R2 row", row_idx, r);
            check("R2 strobe", row_strobe_n, ~(32'h1 << r) & 32'hFFFF);
        end
    endtask

    task automatic t_beep;
        write_ctrl(8'h10);
        check("R3 on", beep_en, 1);
        write_ctrl(8'h02);
        check("R3 off", beep_en, 0);
    endtask

    task automatic t_gate;
        col_n = 8'h5A;
        repeat (3) @(negedge clk);
        write_ctrl(8'h02);
        check("R4 closed", rd_data, 8'h00);
        write_ctrl(8'h22);
        check("R5 open", rd_data, 8'hA5);
        write_ctrl(8'h02);
        check("R4 closed again", rd_data, 8'h00);
    endtask

    task automatic t_sync;
        write_ctrl(8'h27);
        check("R5 before", rd_data, 8'hA5);
        col_n = 8'h0F;
        @(negedge clk);
        check("R5 one edge", rd_data, 8'hA5);
        @(negedge clk);
        check("R5 two edges", rd_data, 8'hF0);
        col_n = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        check("R5 released", rd_data, 8'h00);
    endtask

    task automatic t_upper;
        write_ctrl(8'hC3);
        check("R6 byte", kbd_ctrl, 8'hC3);
        check("R6 row", row_idx, 3);
        check("R6 beep", beep_en, 0);
        check("R6 gate", rd_data, 0);
    endtask

    task automatic t_leds;
        write_ctrl(8'h0F);
        check("R9 start", {led_caps, led_alt}, 2'b00);
        write_ctrl(8'h0D);
        check("R7 caps", {led_caps, led_alt}, 2'b10);
        write_ctrl(8'h05);
        check("R10 plain", {led_caps, led_alt}, 2'b10);
        write_ctrl(8'h0E);
        check("R8 alt", {led_caps, led_alt}, 2'b11);
        repeat (4) @(negedge clk);
        check("R10 idle", {led_caps, led_alt}, 2'b11);
        write_ctrl(8'h3C);
        check("R10 row12", {led_caps, led_alt}, 2'b11);
        write_ctrl(8'h1F);
        check("R9 off", {led_caps, led_alt}, 2'b00);
        write_ctrl(8'h0E);
        check("R8 alone", {led_caps, led_alt}, 2'b01);
        write_ctrl(8'h0D);
        check("R7 keeps alt", {led_caps, led_alt}, 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rows();
        t_beep();
        t_gate();
        t_sync();
        t_upper();
        t_leds();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule